// File: doc/BRIEF.md
# Free Hole Allocation Selector

This block holds a small table of free memory holes, each described by a start address and a length. An allocation request names a length. The block walks the table one entry per clock, starting at index 0, and picks a hole under one of three placement policies chosen with the request: first-fit, best-fit or worst-fit. It returns the chosen hole's start address, then trims the hole from the front by the requested length. A hole that the request uses up completely leaves the table.

Software or a controller fills the table through a simple write port. Requests use a valid/ready handshake, and only one request is in flight at a time. Every request gets exactly one single-cycle response, which carries a success flag and an address. Releasing memory and merging neighbouring holes are not part of this block.

Top module: `hole_alloc`

## Requirements
- R1: After reset, req_ready is high, rsp_valid is low and every table entry is empty, so any request fails.
- R2: While the block is idle, a write with wr_en loads entry wr_idx with address wr_base and length wr_size. The entry is valid only if wr_size is nonzero, so writing a length of zero removes the entry.
- R3: A write presented while a scan is running is ignored and leaves the table unchanged.
- R4: Under first-fit, the block chooses the lowest-index valid hole whose length is at least the request. It stops scanning there, so the response comes k+1 cycles after acceptance, where k is that index.
- R5: Under best-fit, the block chooses the smallest valid hole that fits. On a tie it takes the lower index. The response comes ENTRIES cycles after acceptance.
- R6: Under worst-fit, the block chooses the largest valid hole, provided it fits. On a tie it takes the lower index. The response comes ENTRIES cycles after acceptance.
- R7: The policy encoding on req_policy is 0 for first-fit, 1 for best-fit, 2 for worst-fit and 3 for first-fit. The block samples the policy and the length together with the request.
- R8: On success, rsp_ok is 1 and rsp_addr is the hole's old start address. The hole's start address grows by the request and its length shrinks by the request. If the length reaches zero, the entry becomes invalid.
- R9: If no valid hole fits, or the request length is zero, the response has rsp_ok 0 and rsp_addr 0 and the table is unchanged. A failed first-fit request answers ENTRIES cycles after acceptance.
- R10: req_ready falls in the cycle after acceptance and returns high in the response cycle. rsp_valid is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | IW | Entry to write |
| wr_base | input | AW | Hole start address |
| wr_size | input | SW | Hole length, zero removes the entry |
| req_valid | input | 1 | Allocation request present |
| req_ready | output | 1 | Block idle, able to take a request |
| req_size | input | SW | Requested length |
| req_policy | input | 2 | Placement policy |
| rsp_valid | output | 1 | Response pulse |
| rsp_ok | output | 1 | Allocation succeeded |
| rsp_addr | output | AW | Allocated start address, or 0 on failure |

## Verification
Each response is due a fixed number of cycles after acceptance. For a first-fit hit at index k it is due k+1 cycles later, and in every other case it is due ENTRIES cycles later. req_ready must be low in the cycles between acceptance and the response. The reference model in the bench computes the outcome when the request is accepted and loads a countdown with the due latency. On every falling edge it compares req_ready and rsp_valid, and in the response cycle it also compares the flag and the address, so a response that arrives one cycle early or late is reported. Changes to the table are checked through the addresses that later requests receive.

// File: rtl/hole_alloc.sv
module hole_alloc #(
  parameter int ENTRIES = 8,
  parameter int AW = 16,
  parameter int SW = 16,
  parameter int IW = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-1:0] wr_base,
  input  logic [SW-1:0] wr_size,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [SW-1:0] req_size,
  input  logic [1:0]    req_policy,
  output logic          rsp_valid,
  output logic          rsp_ok,
  output logic [AW-1:0] rsp_addr
);

  logic [AW-1:0]      base_q [ENTRIES];
  logic [SW-1:0]      size_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;

  logic          busy_q;
  logic [IW-1:0] idx_q;
  logic [SW-1:0] rsize_q;
  logic [1:0]    pol_q;
  logic          hit_q;
  logic [IW-1:0] hit_idx_q;
  logic [SW-1:0] hit_size_q;

  logic          fits, first_mode, better, last, done, sel_ok;
  logic [IW-1:0] sel;

  assign req_ready  = !busy_q;
  assign fits       = vld_q[idx_q] && (size_q[idx_q] >= rsize_q) && (rsize_q != '0);
  assign first_mode = (pol_q == 2'd0) || (pol_q == 2'd3);
  assign better     = fits && (!hit_q ||
                      ((pol_q == 2'd1) ? (size_q[idx_q] < hit_size_q)
                                       : (size_q[idx_q] > hit_size_q)));
  assign last       = (idx_q == IW'(ENTRIES - 1));
  assign done       = busy_q && (last || (first_mode && fits));
  assign sel_ok     = better || hit_q;
  assign sel        = better ? idx_q : hit_idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        base_q[i] <= '0;
        size_q[i] <= '0;
      end
      vld_q      <= '0;
      busy_q     <= 1'b0;
      idx_q      <= '0;
      rsize_q    <= '0;
      pol_q      <= '0;
      hit_q      <= 1'b0;
      hit_idx_q  <= '0;
      hit_size_q <= '0;
      rsp_valid  <= 1'b0;
      rsp_ok     <= 1'b0;
      rsp_addr   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (!busy_q) begin
        if (wr_en) begin
          base_q[wr_idx] <= wr_base;
          size_q[wr_idx] <= wr_size;
          vld_q[wr_idx]  <= (wr_size != '0);
        end
        if (req_valid) begin
          busy_q  <= 1'b1;
          idx_q   <= '0;
          rsize_q <= req_size;
          pol_q   <= req_policy;
          hit_q   <= 1'b0;
        end
      end else if (done) begin
        busy_q    <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_ok    <= sel_ok;
        rsp_addr  <= sel_ok ? base_q[sel] : '0;
        if (sel_ok) begin
          base_q[sel] <= base_q[sel] + AW'(rsize_q);
          size_q[sel] <= size_q[sel] - rsize_q;
          if (size_q[sel] == rsize_q) vld_q[sel] <= 1'b0;
        end
      end else begin
        if (better) begin
          hit_q      <= 1'b1;
          hit_idx_q  <= idx_q;
          hit_size_q <= size_q[idx_q];
        end
        idx_q <= idx_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/hole_alloc_chk.sv
module hole_alloc_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ok,
  input logic [AW-1:0] rsp_addr
);

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R10
  AST_RSP_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R10
  AST_RSP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready); // R10
  AST_RSP_ENDS_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!req_ready)); // R10
  AST_FAIL_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ok) |-> (rsp_addr == '0)); // R9

endmodule

bind hole_alloc hole_alloc_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_addr(rsp_addr)
);

// File: tb/hole_alloc_bench.sv
module hole_alloc_bench;
  localparam int N  = 8;
  localparam int AW = 16;
  localparam int SW = 16;
  localparam int IW = 3;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [IW-1:0] wr_idx = '0;
  logic [AW-1:0] wr_base = '0;
  logic [SW-1:0] wr_size = '0;
  logic req_valid = 0;
  logic [SW-1:0] req_size = '0;
  logic [1:0] req_policy = '0;
  logic req_ready, rsp_valid, rsp_ok;
  logic [AW-1:0] rsp_addr;

  always #2 clk = ~clk;

  hole_alloc #(.ENTRIES(N), .AW(AW), .SW(SW)) u_hole_alloc (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_base(wr_base),
    .wr_size(wr_size), .req_valid(req_valid), .req_ready(req_ready),
    .req_size(req_size), .req_policy(req_policy), .rsp_valid(rsp_valid),
    .rsp_ok(rsp_ok), .rsp_addr(rsp_addr));

  int vectors = 0, errors = 0, cycles = 0;
  string tag = "R1";

  int mbase [N];
  int msize [N];
  int mcnt = 0;
  bit e_rv = 0, e_ok = 0, p_ok = 0;
  int e_addr = 0, p_addr = 0;

  // Reference model: outcome decided at acceptance, released after the due latency
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin mbase[i] = 0; msize[i] = 0; end
      mcnt = 0; e_rv = 0;
    end else if (mcnt > 0) begin
      mcnt--;
      e_rv = (mcnt == 0);
      if (e_rv) begin e_ok = p_ok; e_addr = p_addr; end
    end else begin
      int pick, rs, lat;
      e_rv = 0;
      if (wr_en) begin mbase[wr_idx] = int'(wr_base); msize[wr_idx] = int'(wr_size); end
      if (req_valid) begin
        rs = int'(req_size); pick = -1; lat = N;
        for (int i = 0; i < N; i++) begin
          if (rs > 0 && msize[i] >= rs) begin
            if (req_policy == 2'd1) begin
              if (pick < 0 || msize[i] < msize[pick]) pick = i;
            end else if (req_policy == 2'd2) begin
              if (pick < 0 || msize[i] > msize[pick]) pick = i;
            end else if (pick < 0) begin
              pick = i; lat = i + 1;
            end
          end
        end
        p_ok = (pick >= 0);
        p_addr = 0;
        if (p_ok) begin
          p_addr = mbase[pick];
          mbase[pick] = (mbase[pick] + rs) % 65536;
          msize[pick] = msize[pick] - rs;
        end
        mcnt = lat;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      vectors++;
      if (req_ready !== (mcnt == 0)) begin
        errors++;
        $display("FAIL %s req_ready actual=%b expected=%b", tag, req_ready, mcnt == 0);
      end
      if (rsp_valid !== e_rv) begin
        errors++;
        $display("FAIL %s rsp_valid actual=%b expected=%b", tag, rsp_valid, e_rv);
      end else if (e_rv && (rsp_ok !== e_ok || int'(rsp_addr) != e_addr)) begin
        errors++;
        $display("FAIL %s rsp ok/addr actual=%b/%0d expected=%b/%0d",
                 tag, rsp_ok, rsp_addr, e_ok, e_addr);
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog %s actual=hung expected=finished", tag);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic wr(input int idx, input int b, input int s);
    @(negedge clk);
    wr_en = 1; wr_idx = IW'(idx); wr_base = AW'(b); wr_size = SW'(s);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic alloc(input int pol, input int s);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_policy = 2'(pol); req_size = SW'(s);
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tag = "R1";
    alloc(0, 1);
    tag = "R2";
    wr(0, 100, 50); wr(1, 200, 20); wr(2, 300, 80); wr(3, 400, 20); wr(5, 600, 120);
    tag = "R4"; alloc(0, 30);
    tag = "R5"; alloc(1, 15);
    tag = "R6"; alloc(2, 40);
    tag = "R6"; alloc(2, 10);
    tag = "R8"; alloc(0, 5);
    tag = "R8"; alloc(0, 5);
    tag = "R9"; alloc(1, 500);
    tag = "R9"; alloc(2, 0);
    tag = "R7"; alloc(3, 60);
    tag = "R2"; wr(1, 0, 0); alloc(0, 20);
    tag = "R3";
    @(negedge clk);
    req_valid = 1; req_policy = 2'd1; req_size = SW'(5);
    @(negedge clk);
    req_valid = 0;
    wr_en = 1; wr_idx = 3'd7; wr_base = AW'(900); wr_size = SW'(3);
    @(negedge clk);
    wr_en = 0;
    while (!rsp_valid) @(negedge clk);
    alloc(1, 3);
    tag = "R10";
    for (int k = 0; k < 80; k++) begin
      if (k % 4 == 0) wr(int'($urandom_range(0, 7)), int'($urandom_range(0, 4000)),
                         int'($urandom_range(0, 60)));
      alloc(int'($urandom_range(0, 3)), int'($urandom_range(0, 40)));
    end
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule